// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches the already-synchronized levels of a port's pins and decides, pin by pin, when to latch an interrupt. Each pin has its own trigger settings. It can be level sensitive or edge sensitive. A polarity bit chooses the active level or the active edge. In edge mode, a both-edges bit makes either transition latch, whatever the polarity bit holds. A latched event stays in a sticky pending bit until software acknowledges it with a write-1-to-clear pulse vector. Bus decoding and synchronization of the pins happen outside this block.

Every pin's pending bit is a two-state machine. The states are `PS_IDLE` (nothing pending) and `PS_PEND` (an interrupt is pending). There are three named transitions:
- `T_LATCH`: from `PS_IDLE` to `PS_PEND` when the trigger condition is present.
- `T_ACK`: from `PS_PEND` to `PS_IDLE` when the clear bit is 1 and no new trigger arrives in that cycle.
- `T_HOLD`: stay in `PS_PEND` in every other case.

Two request outputs combine the pending vector. `irq_req` is the OR of the pending bits whose interrupt enable is set. `wake_req` is the OR of the pending bits whose wake enable is set. Both are driven directly from the registered pending bits.

Top module: `gpio_irq_detect`

## Requirements
- R1: While `rst_n` is low, `pend` is all zero and `irq_req` and `wake_req` are 0; the stored previous level resets to 0.
- R2: With `trig_mode[i]`=0 (level), pin i latches pending on the clock edge where `pin_lvl[i]` equals `trig_pol[i]` (1 = high active, 0 = low active); `both_edge[i]` has no effect in level mode.
- R3: With `trig_mode[i]`=1 and `both_edge[i]`=0, pin i latches only when its level differs from the level sampled on the previous clock: 0-to-1 if `trig_pol[i]`=1, 1-to-0 if `trig_pol[i]`=0; a steady level or the opposite edge latches nothing.
- R4: With `trig_mode[i]`=1 and `both_edge[i]`=1, both a 0-to-1 and a 1-to-0 change of pin i latch pending, for either value of `trig_pol[i]`.
- R5: A pending bit stays 1 until a cycle where `ack_w1c[i]`=1; `ack_w1c` bits that are 0 leave their pending bit unchanged.
- R6: If a trigger and a clear hit the same bit in one cycle, the bit stays 1; in level mode a bit therefore cannot be cleared while its active level persists.
- R7: `irq_req` is 1 exactly when some bit i has `pend[i]`=1 and `irq_en[i]`=1.
- R8: `wake_req` is 1 exactly when some bit i has `pend[i]`=1 and `wake_en[i]`=1.
- R9: `pend` changes only on a rising clock edge and reflects the inputs sampled at that edge; the request outputs follow `pend` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | N_PINS | Synchronized pin levels |
| trig_mode | input | N_PINS | 0 = level trigger, 1 = edge trigger |
| trig_pol | input | N_PINS | 1 = high/rising, 0 = low/falling |
| both_edge | input | N_PINS | Both-edges override, edge mode only |
| irq_en | input | N_PINS | Per-pin interrupt enable |
| wake_en | input | N_PINS | Per-pin wake enable |
| ack_w1c | input | N_PINS | Write-1-to-clear pulse for pending bits |
| pend | output | N_PINS | Pending status per pin |
| irq_req | output | 1 | Combined interrupt request |
| wake_req | output | 1 | Combined wake request |

## Verification
The bench holds one fixed setup in which the eight combinations of mode, polarity and both-edges repeat across the 32 pins. It then drives that setup with level patterns: all low, all high, alternating nibbles, their inverse, and a single pin. A pin that latches on the wrong polarity, on a steady level, or on only one edge in both-edges mode fails in its own bit position. Directed steps then isolate cases that the patterns cannot separate:
- a clear that arrives together with a fresh edge;
- a clear applied while the active level is still present;
- partial clear masks;
- both-edges set while in level mode;
- sparse enable masks on the two request outputs;
- a reset applied in the middle of a run.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_PEND = 1'b1
    } pend_state_e;
endpackage

// File: rtl/gpio_edge_sense.sv
// Registers the previous synchronized level and derives rise/fall strobes.
module gpio_edge_sense #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] lvl,
    output logic [N_PINS-1:0] rise,
    output logic [N_PINS-1:0] fall
);
    logic [N_PINS-1:0] lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    always_comb begin
        rise = lvl & ~lvl_q;
        fall = ~lvl & lvl_q;
    end
endmodule

// File: rtl/gpio_trig_select.sv
// Per-pin choice of trigger condition from mode, polarity and both-edges.
module gpio_trig_select #(
    parameter int N_PINS = 32
) (
    input  logic [N_PINS-1:0] lvl,
    input  logic [N_PINS-1:0] rise,
    input  logic [N_PINS-1:0] fall,
    input  logic [N_PINS-1:0] mode,
    input  logic [N_PINS-1:0] pol,
    input  logic [N_PINS-1:0] dual,
    output logic [N_PINS-1:0] hit
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic edge_hit;
        logic level_hit;
        assign edge_hit  = dual[i] ? (rise[i] | fall[i])
                                   : (pol[i] ? rise[i] : fall[i]);
        assign level_hit = pol[i] ? lvl[i] : ~lvl[i];
        assign hit[i]    = mode[i] ? edge_hit : level_hit;
    end
endmodule

// File: rtl/gpio_pend_cell.sv
// One pin's pending state machine: PS_IDLE / PS_PEND.
module gpio_pend_cell
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack,
    output logic pend
);
    pend_state_e st_q;
    pend_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_IDLE: if (hit) st_d = PS_PEND;            // T_LATCH
            PS_PEND: if (ack && !hit) st_d = PS_IDLE;    // T_ACK, else T_HOLD
        endcase
    end

    always_comb begin
        pend = (st_q == PS_PEND);
    end
endmodule

// File: rtl/gpio_req_merge.sv
// Masked OR-reduction of the pending vector into one request line.
module gpio_req_merge #(
    parameter int N_PINS = 32
) (
    input  logic [N_PINS-1:0] pend,
    input  logic [N_PINS-1:0] enable,
    output logic              req
);
    always_comb begin
        req = |(pend & enable);
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_lvl,
    input  logic [N_PINS-1:0] trig_mode,
    input  logic [N_PINS-1:0] trig_pol,
    input  logic [N_PINS-1:0] both_edge,
    input  logic [N_PINS-1:0] irq_en,
    input  logic [N_PINS-1:0] wake_en,
    input  logic [N_PINS-1:0] ack_w1c,
    output logic [N_PINS-1:0] pend,
    output logic              irq_req,
    output logic              wake_req
);
    logic [N_PINS-1:0] rise;
    logic [N_PINS-1:0] fall;
    logic [N_PINS-1:0] hit;

    gpio_edge_sense #(.N_PINS(N_PINS)) u_sense (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (pin_lvl),
        .rise (rise),
        .fall (fall)
    );

    gpio_trig_select #(.N_PINS(N_PINS)) u_trig (
        .lvl (pin_lvl),
        .rise(rise),
        .fall(fall),
        .mode(trig_mode),
        .pol (trig_pol),
        .dual(both_edge),
        .hit (hit)
    );

    for (genvar i = 0; i < N_PINS; i++) begin : g_cell
        gpio_pend_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .hit  (hit[i]),
            .ack  (ack_w1c[i]),
            .pend (pend[i])
        );
    end

    gpio_req_merge #(.N_PINS(N_PINS)) u_irq (
        .pend  (pend),
        .enable(irq_en),
        .req   (irq_req)
    );

    gpio_req_merge #(.N_PINS(N_PINS)) u_wake (
        .pend  (pend),
        .enable(wake_en),
        .req   (wake_req)
    );
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
    parameter int N_PINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PINS-1:0] pin_lvl,
    input logic [N_PINS-1:0] trig_mode,
    input logic [N_PINS-1:0] trig_pol,
    input logic [N_PINS-1:0] both_edge,
    input logic [N_PINS-1:0] irq_en,
    input logic [N_PINS-1:0] wake_en,
    input logic [N_PINS-1:0] ack_w1c,
    input logic [N_PINS-1:0] pend,
    input logic              irq_req,
    input logic              wake_req
);
    // counts cycles since reset so two-deep history is valid
    logic [1:0] age;
    logic       hist_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end
    assign hist_ok = (age == 2'd3);

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |-> (pend == '0 && !irq_req && !wake_req));

    a_r2_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(trig_mode) & ~($past(trig_pol) ^ $past(pin_lvl)) & ~pend) == '0));

    a_r3_steady_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |=> ((pend & ~$past(pend) & $past(trig_mode)
                      & ~($past(pin_lvl) ^ $past(pin_lvl, 2))) == '0));

    a_r4_dual_latches: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |=> (($past(trig_mode) & $past(both_edge)
                      & ($past(pin_lvl) ^ $past(pin_lvl, 2)) & ~pend) == '0));

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend) & ~$past(ack_w1c) & ~pend) == '0));

    a_r7_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend != '0 && irq_en != '0));

    a_r8_wake_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (pend != '0 && wake_en != '0));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.N_PINS(N_PINS)) u_chk (.*);

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/1ps
module sim_gpio_irq_detect;
    localparam int N = 32;
    localparam int NV = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_lvl = '0, trig_mode = '0, trig_pol = '0, both_edge = '0;
    logic [N-1:0] irq_en = '0, wake_en = '0, ack_w1c = '0;
    logic [N-1:0] pend;
    logic         irq_req, wake_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gpio_irq_detect #(.N_PINS(N)) u0 (.*);

    // stimulus vectors: level, clear, irq enable, wake enable
    localparam logic [N-1:0] V_LVL [NV] = '{32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0,
        32'hA5A5A5A5, 32'h5A5A5A5A, 32'h5A5A5A5A, 32'h0, 32'h1, 32'h0, 32'h0};
    localparam logic [N-1:0] V_CLR [NV] = '{32'h0, 32'h0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF,
        32'h0, 32'h0000FFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'h0};
    localparam logic [N-1:0] V_IEN [NV] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
        32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'h0, 32'h1, 32'h1, 32'hFFFFFFFF, 32'hFFFFFFFF};
    localparam logic [N-1:0] V_WEN [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'hF0F0F0F0, 32'h0, 32'h80000000, 32'h80000000, 32'hFFFFFFFF, 32'hFFFFFFFF};

    logic [N-1:0] m_prev = '0, m_pend = '0;

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // directed step: called at a negedge, returns at the next negedge
    task automatic step(input logic [N-1:0] lvl, input logic [N-1:0] clr,
                        input logic [N-1:0] exp_pend, input string tag);
        pin_lvl = lvl; ack_w1c = clr;
        @(posedge clk); #1;
        check(tag, pend, exp_pend);
        check({tag, " irq"}, {31'b0, irq_req}, {31'b0, |(exp_pend & irq_en)});
        @(negedge clk);
    endtask

    initial begin
        // R1 reset state with the mixed setup applied
        trig_mode = 32'hF0F0F0F0; trig_pol = 32'hCCCCCCCC; both_edge = 32'hAAAAAAAA;
        repeat (3) @(negedge clk);
        check("R1 reset pend", pend, '0);
        check("R1 reset irq/wake", {30'b0, irq_req, wake_req}, '0);
        rst_n = 1'b1;

        // vector table: R2 R3 R4 R5 R6 R7 R8 R9 against a requirement-level model
        for (int v = 0; v < NV; v++) begin
            logic [N-1:0] rise, fall, eh, lh, hit;
            pin_lvl = V_LVL[v]; ack_w1c = V_CLR[v]; irq_en = V_IEN[v]; wake_en = V_WEN[v];
            rise = pin_lvl & ~m_prev;
            fall = ~pin_lvl & m_prev;
            eh = (both_edge & (rise | fall)) | (~both_edge & trig_pol & rise)
               | (~both_edge & ~trig_pol & fall);
            lh = (trig_pol & pin_lvl) | (~trig_pol & ~pin_lvl);
            hit = (trig_mode & eh) | (~trig_mode & lh);
            @(posedge clk); #1;
            m_pend = hit | (m_pend & ~ack_w1c);
            m_prev = pin_lvl;
            check($sformatf("R2/R3/R4/R5/R9 vector %0d pend", v), pend, m_pend);
            check($sformatf("R7 vector %0d irq", v), {31'b0, irq_req}, {31'b0, |(m_pend & irq_en)});
            check($sformatf("R8 vector %0d wake", v), {31'b0, wake_req}, {31'b0, |(m_pend & wake_en)});
            @(negedge clk);
        end

        // edge mode, rising only
        trig_mode = '1; trig_pol = '1; both_edge = '0; irq_en = '1; wake_en = '0;
        step(32'h0, '1, 32'h0, "R5 clear all");
        step(32'h8, '0, 32'h8, "R3 rising latches");
        step(32'h8, '0, 32'h8, "R5 sticky");
        step(32'h8, 32'h4, 32'h8, "R5 zero clear bit no effect");
        step(32'h8, 32'h8, 32'h0, "R5 clear");
        step(32'h0, '0, 32'h0, "R3 falling ignored");
        step(32'h8, 32'h8, 32'h8, "R6 edge beats clear");
        both_edge = '1;
        step(32'h0, '1, 32'h8, "R4 falling latches with dual");
        step(32'h0, '1, 32'h0, "R4 clear after dual");

        // level mode, high active
        trig_mode = '0; trig_pol = '1; both_edge = '0;
        step(32'h0, '1, 32'h0, "R2 no active level");
        step(32'h20, '0, 32'h20, "R2 high level latches");
        step(32'h20, '1, 32'h20, "R6 level persists over clear");
        step(32'h0, '1, 32'h0, "R6 clear after level gone");

        // level mode with dual set: dual ignored
        trig_pol = '0; both_edge = '1;
        step(32'h0, '0, 32'hFFFFFFFF, "R4 dual in level mode low active");
        step(32'hFFFFFFFF, '1, 32'h0, "R4 dual in level mode no edge latch");

        // enable masks
        both_edge = '0;
        irq_en = '0; wake_en = '0;
        step(32'h0, '0, 32'hFFFFFFFF, "R7 masked pend");
        check("R7 irq masked", {31'b0, irq_req}, 32'h0);
        check("R8 wake masked", {31'b0, wake_req}, 32'h0);
        irq_en = 32'h80000000; wake_en = 32'h1;
        #1;
        check("R7 irq single enable", {31'b0, irq_req}, 32'h1);
        check("R8 wake single enable", {31'b0, wake_req}, 32'h1);

        // reset mid-run
        #1 rst_n = 1'b0;
        #1;
        check("R1 async reset pend", pend, '0);
        check("R1 async reset requests", {30'b0, irq_req, wake_req}, '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule